// File: doc/BRIEF.md
# MSI capability register file

This block holds the message-signalled interrupt capability of one PCI function inside its configuration space. Configuration software reaches it through dword-addressed reads and writes with per-byte enables, where the dword index is relative to the start of the capability. It keeps the control word, the message address (one or two dwords), the message data, and, when per-vector masking is built in, the per-vector mask and pending words.

Three build-time parameters choose the shape: the log2 of the requested vector count, whether the address is 64 bits wide, and whether per-vector masking exists. These choices move the data, mask and pending words to different dword slots and change how long the capability is. Accesses that fall past its end read zero and change nothing. The decoded enable, the granted vector count, the address, the data, the mask and the pending bits are driven out continuously to a message generator. That generator sets and clears pending bits through its own input pair.

Top module: `msi_cap_regfile`

## Requirements
- R1: After reset the enable bit, the granted-vectors field, both address dwords, the data word, the mask word and the pending word read zero. The requested-vectors field, the 64-bit flag and the masking flag keep their build values.
- R2: Dword 0 reads {7'b0, mask flag [24], 64-bit flag [23], granted log2 [22:20], requested log2 [19:17], enable [16], 8'h00, 8'h05}. Dword 1 is the low address. With 64-bit addressing, dwords 2 to 5 are high address, data, mask and pending. Without it, dwords 2 to 4 are data, mask and pending.
- R3: The requested-vectors field, the 64-bit flag, the masking flag and the low half of dword 0 ignore writes.
- R4: The low address dword is writable except bits [1:0], which read zero. The high address dword exists and is writable only with 64-bit addressing; otherwise the upper 32 address bits are zero.
- R5: The data word stores bits [15:0] of a write; bits [31:16] of that dword read zero.
- R6: A write changes only the bytes whose byte enable is set. The enable bit and the granted field sit in byte 2 of dword 0.
- R7: Only mask bits 0 to 2^requested−1 are writable; higher mask bits stay zero.
- R8: A granted-vectors value written above the requested value is stored as the requested value.
- R9: After any write whose dword index lies inside the capability, pending bits at or above 2^granted are zero, using the granted value that write leaves behind.
- R10: Configuration writes never set pending bits. A set request from the generator takes effect only below 2^requested. A clear request wins over a set request for the same bit in the same cycle.
- R11: A dword index past the capability length (24, 20, 14 or 10 bytes, rounded up to dwords) reads zero, and a write there changes no register and does not trim pending bits.
- R12: The outputs msi_enable, vec_en_log2, msg_addr, msg_data, vec_mask and vec_pend follow the stored registers.
- R13: Without per-vector masking there is no mask or pending word: vec_mask and vec_pend stay zero, and generator requests are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pend_set | input | 32 | Generator requests to set pending bits |
| pend_clr | input | 32 | Generator requests to clear pending bits |
| msi_enable | output | 1 | Stored enable bit |
| vec_en_log2 | output | 3 | Stored granted-vectors log2 |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pend | output | 32 | Per-vector pending bits |

## Verification
The bench builds three copies. The first has 8 requested vectors, a 64-bit address and masking, which gives the six-dword layout, the clamp above 3 and mask bits cut off at bit 7. The second has 32 vectors, a 32-bit address and masking, which moves data, mask and pending down one dword and makes every mask bit writable. The third has one vector and no address extension or masking, which gives the shortest window, a clamp to zero and absent mask and pending words.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned MSI_VEC_MAX = 32;
  localparam int unsigned CFG_DW_AW   = 3;
  localparam logic [7:0]  MSI_CAP_ID  = 8'h05;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HDR,
    SEL_ALO,
    SEL_AHI,
    SEL_DATA,
    SEL_MASK,
    SEL_PEND
  } msi_sel_e;

  // Capability length in bytes for each option pair.
  function automatic int unsigned cap_bytes(input bit a64, input bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  function automatic int unsigned cap_dwords(input bit a64, input bit pvm);
    return (cap_bytes(a64, pvm) + 3) / 4;
  endfunction

  // Ones in bits [n-1:0]; saturates at the full word.
  function automatic logic [MSI_VEC_MAX-1:0] low_ones(input int unsigned n);
    if (n >= MSI_VEC_MAX) return '1;
    return (MSI_VEC_MAX'(1) << n) - MSI_VEC_MAX'(1);
  endfunction

endpackage

// File: rtl/msi_cap_rst_sync.sv
module msi_cap_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit PVM    = 1'b1
) (
  input  logic [CFG_DW_AW-1:0] addr,
  output msi_sel_e             sel,
  output logic                 hit
);
  localparam logic [CFG_DW_AW:0] WIN = (CFG_DW_AW+1)'(cap_dwords(ADDR64, PVM));

  always_comb begin
    hit = ({1'b0, addr} < WIN);
    sel = SEL_NONE;
    if (hit) begin
      case (addr)
        3'd0:    sel = SEL_HDR;
        3'd1:    sel = SEL_ALO;
        3'd2:    sel = ADDR64 ? SEL_AHI : SEL_DATA;
        3'd3:    sel = ADDR64 ? SEL_DATA : (PVM ? SEL_MASK : SEL_NONE);
        3'd4:    sel = PVM ? (ADDR64 ? SEL_MASK : SEL_PEND) : SEL_NONE;
        3'd5:    sel = (PVM && ADDR64) ? SEL_PEND : SEL_NONE;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int unsigned CAP_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_enable,
  input  logic [2:0] wr_log2,
  output logic       enable_q,
  output logic [2:0] en_log2_q,
  output logic [2:0] en_log2_nxt
);
  localparam logic [2:0] CAP_F = 3'(CAP_LOG2);

  logic enable_nxt;

  always_comb begin
    enable_nxt  = enable_q;
    en_log2_nxt = en_log2_q;
    if (wr_en) begin
      enable_nxt  = wr_enable;
      en_log2_nxt = (wr_log2 > CAP_F) ? CAP_F : wr_log2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      en_log2_q <= 3'd0;
    end else if (wr_en) begin
      enable_q  <= enable_nxt;
      en_log2_q <= en_log2_nxt;
    end
  end
endmodule

// File: rtl/msi_cap_msgregs.sv
module msi_cap_msgregs #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_alo,
  input  logic        wr_ahi,
  input  logic        wr_data,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] addr_lo_q,
  output logic [31:0] addr_hi_q,
  output logic [15:0] data_q
);
  logic [31:0] alo_nxt;
  logic [15:0] data_nxt;
  logic        alo_upd, data_upd;

  assign alo_upd  = wr_alo  & (|be);
  assign data_upd = wr_data & (|be[1:0]);

  always_comb begin
    alo_nxt = addr_lo_q;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) alo_nxt[8*i +: 8] = wdata[8*i +: 8];
    end
    alo_nxt[1:0] = 2'b00;
  end

  always_comb begin
    data_nxt = data_q;
    for (int i = 0; i < 2; i++) begin
      if (be[i]) data_nxt[8*i +: 8] = wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_lo_q <= 32'd0;
    else if (alo_upd) addr_lo_q <= alo_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= 16'd0;
    else if (data_upd) data_q <= data_nxt;
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] ahi_nxt;
      logic        ahi_upd;
      assign ahi_upd = wr_ahi & (|be);
      always_comb begin
        ahi_nxt = addr_hi_q;
        for (int i = 0; i < 4; i++) begin
          if (be[i]) ahi_nxt[8*i +: 8] = wdata[8*i +: 8];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_hi_q <= 32'd0;
        else if (ahi_upd) addr_hi_q <= ahi_nxt;
      end
    end else begin : g_no_hi
      logic unused_hi;
      assign unused_hi = wr_ahi;
      assign addr_hi_q = 32'd0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_vecbits.sv
module msi_cap_vecbits
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          PVM      = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_mask,
  input  logic                   cap_wr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic [2:0]             en_log2_nxt,
  input  logic [MSI_VEC_MAX-1:0] pend_set,
  input  logic [MSI_VEC_MAX-1:0] pend_clr,
  output logic [MSI_VEC_MAX-1:0] mask_q,
  output logic [MSI_VEC_MAX-1:0] pend_q
);
  localparam int unsigned NVEC = 1 << CAP_LOG2;

  generate
    if (PVM) begin : g_pvm
      localparam logic [MSI_VEC_MAX-1:0] CAP_M = low_ones(NVEC);
      logic [MSI_VEC_MAX-1:0] mask_nxt, pend_nxt, trim_m;
      logic                   mask_upd, pend_upd;

      assign mask_upd = wr_mask & (|be);
      assign pend_upd = cap_wr | (|pend_set) | (|pend_clr);
      assign trim_m   = low_ones(int'(1) << en_log2_nxt);

      always_comb begin
        mask_nxt = mask_q;
        for (int i = 0; i < 4; i++) begin
          if (be[i]) mask_nxt[8*i +: 8] = wdata[8*i +: 8];
        end
        mask_nxt = mask_nxt & CAP_M;
      end

      always_comb begin
        pend_nxt = (pend_q | (pend_set & CAP_M)) & ~pend_clr;
        if (cap_wr) pend_nxt = pend_nxt & trim_m;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (mask_upd) mask_q <= mask_nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_upd) pend_q <= pend_nxt;
      end
    end else begin : g_no_pvm
      logic unused_vec;
      assign unused_vec = ^{clk, rst_n, wr_mask, cap_wr, be, wdata,
                            en_log2_nxt, pend_set, pend_clr};
      assign mask_q = '0;
      assign pend_q = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVM      = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_DW_AW-1:0]   cfg_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [MSI_VEC_MAX-1:0] pend_set,
  input  logic [MSI_VEC_MAX-1:0] pend_clr,
  output logic                   msi_enable,
  output logic [2:0]             vec_en_log2,
  output logic [63:0]            msg_addr,
  output logic [15:0]            msg_data,
  output logic [MSI_VEC_MAX-1:0] vec_mask,
  output logic [MSI_VEC_MAX-1:0] vec_pend
);
  localparam logic [2:0] CAP_F = 3'(CAP_LOG2);

  logic        rst_n_int;
  msi_sel_e    sel;
  logic        hit, cap_wr;
  logic        wr_hdr, wr_alo, wr_ahi, wr_data, wr_mask;
  logic        enable_q;
  logic [2:0]  en_log2_q, en_log2_nxt;
  logic [31:0] addr_lo_q, addr_hi_q;
  logic [15:0] data_q;
  logic [MSI_VEC_MAX-1:0] mask_q, pend_q;
  logic [15:0] ctrl_word;

  msi_cap_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  msi_cap_decode #(.ADDR64(ADDR64), .PVM(PVM)) u_dec (
    .addr (cfg_addr),
    .sel  (sel),
    .hit  (hit)
  );

  assign cap_wr  = cfg_we & hit;
  assign wr_hdr  = cfg_we & (sel == SEL_HDR);
  assign wr_alo  = cfg_we & (sel == SEL_ALO);
  assign wr_ahi  = cfg_we & (sel == SEL_AHI);
  assign wr_data = cfg_we & (sel == SEL_DATA);
  assign wr_mask = cfg_we & (sel == SEL_MASK);

  msi_cap_ctrl #(.CAP_LOG2(CAP_LOG2)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_en       (wr_hdr & cfg_be[2]),
    .wr_enable   (cfg_wdata[16]),
    .wr_log2     (cfg_wdata[22:20]),
    .enable_q    (enable_q),
    .en_log2_q   (en_log2_q),
    .en_log2_nxt (en_log2_nxt)
  );

  msi_cap_msgregs #(.ADDR64(ADDR64)) u_msg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_alo    (wr_alo),
    .wr_ahi    (wr_ahi),
    .wr_data   (wr_data),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .addr_lo_q (addr_lo_q),
    .addr_hi_q (addr_hi_q),
    .data_q    (data_q)
  );

  msi_cap_vecbits #(.CAP_LOG2(CAP_LOG2), .PVM(PVM)) u_vec (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_mask     (wr_mask),
    .cap_wr      (cap_wr),
    .be          (cfg_be),
    .wdata       (cfg_wdata),
    .en_log2_nxt (en_log2_nxt),
    .pend_set    (pend_set),
    .pend_clr    (pend_clr),
    .mask_q      (mask_q),
    .pend_q      (pend_q)
  );

  assign ctrl_word = {7'd0, PVM, ADDR64, en_log2_q, CAP_F, enable_q};

  always_comb begin
    case (sel)
      SEL_HDR:  cfg_rdata = {ctrl_word, 8'h00, MSI_CAP_ID};
      SEL_ALO:  cfg_rdata = addr_lo_q;
      SEL_AHI:  cfg_rdata = addr_hi_q;
      SEL_DATA: cfg_rdata = {16'd0, data_q};
      SEL_MASK: cfg_rdata = mask_q;
      SEL_PEND: cfg_rdata = pend_q;
      default:  cfg_rdata = 32'd0;
    endcase
  end

  assign msi_enable  = enable_q;
  assign vec_en_log2 = en_log2_q;
  assign msg_addr    = {addr_hi_q, addr_lo_q};
  assign msg_data    = data_q;
  assign vec_mask    = mask_q;
  assign vec_pend    = pend_q;
endmodule

// File: rtl/msi_cap_regfile_chk.sv
module msi_cap_regfile_chk
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVM      = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [CFG_DW_AW-1:0]   cfg_addr,
  input logic [31:0]            cfg_rdata,
  input logic [MSI_VEC_MAX-1:0] pend_set,
  input logic [MSI_VEC_MAX-1:0] pend_clr,
  input logic [2:0]             vec_en_log2,
  input logic [63:0]            msg_addr,
  input logic [MSI_VEC_MAX-1:0] vec_mask,
  input logic [MSI_VEC_MAX-1:0] vec_pend
);
  localparam int unsigned WIN_DW = cap_dwords(ADDR64, PVM);
  localparam logic [MSI_VEC_MAX-1:0] CAP_M = low_ones(1 << CAP_LOG2);

  logic in_win;
  assign in_win = (int'(cfg_addr) < int'(WIN_DW));

  assert_en_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec_en_log2) <= int'(CAP_LOG2));

  assert_mask_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mask & ~CAP_M) == '0);

  assert_pend_trim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_win) |=> ((vec_pend & ~low_ones(int'(1) << vec_en_log2)) == '0));

  assert_addr_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_addr[1:0] == 2'b00) && (ADDR64 || (msg_addr[63:32] == 32'd0)));

  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && (pend_set == '0) && (pend_clr == '0)) |=> $stable(vec_pend));

  assert_outside_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (cfg_rdata == 32'd0));

  assert_nomask_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    PVM || ((vec_mask == '0) && (vec_pend == '0)));
endmodule

bind msi_cap_regfile msi_cap_regfile_chk #(
  .CAP_LOG2 (CAP_LOG2),
  .ADDR64   (ADDR64),
  .PVM      (PVM)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_rdata   (cfg_rdata),
  .pend_set    (pend_set),
  .pend_clr    (pend_clr),
  .vec_en_log2 (vec_en_log2),
  .msg_addr    (msg_addr),
  .vec_mask    (vec_mask),
  .vec_pend    (vec_pend)
);

// File: tb/msi_cap_regfile_tb_top.sv
module msi_cap_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic        we [3];
  logic [2:0]  ad [3];
  logic [3:0]  be [3];
  logic [31:0] wd [3];
  logic [31:0] ps [3];
  logic [31:0] pc [3];
  logic [31:0] rd_o [3];
  logic        en_o [3];
  logic [2:0]  vl_o [3];
  logic [63:0] ma_o [3];
  logic [15:0] md_o [3];
  logic [31:0] vm_o [3];
  logic [31:0] vp_o [3];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // A: 8 vectors, 64-bit, masking
  msi_cap_regfile #(.CAP_LOG2(3), .ADDR64(1'b1), .PVM(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we[0]), .cfg_addr(ad[0]), .cfg_be(be[0]),
    .cfg_wdata(wd[0]), .cfg_rdata(rd_o[0]), .pend_set(ps[0]), .pend_clr(pc[0]),
    .msi_enable(en_o[0]), .vec_en_log2(vl_o[0]), .msg_addr(ma_o[0]),
    .msg_data(md_o[0]), .vec_mask(vm_o[0]), .vec_pend(vp_o[0]));

  // B: 32 vectors, 32-bit, masking
  msi_cap_regfile #(.CAP_LOG2(5), .ADDR64(1'b0), .PVM(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we[1]), .cfg_addr(ad[1]), .cfg_be(be[1]),
    .cfg_wdata(wd[1]), .cfg_rdata(rd_o[1]), .pend_set(ps[1]), .pend_clr(pc[1]),
    .msi_enable(en_o[1]), .vec_en_log2(vl_o[1]), .msg_addr(ma_o[1]),
    .msg_data(md_o[1]), .vec_mask(vm_o[1]), .vec_pend(vp_o[1]));

  // C: 1 vector, 32-bit, no masking
  msi_cap_regfile #(.CAP_LOG2(0), .ADDR64(1'b0), .PVM(1'b0)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we[2]), .cfg_addr(ad[2]), .cfg_be(be[2]),
    .cfg_wdata(wd[2]), .cfg_rdata(rd_o[2]), .pend_set(ps[2]), .pend_clr(pc[2]),
    .msi_enable(en_o[2]), .vec_en_log2(vl_o[2]), .msg_addr(ma_o[2]),
    .msg_data(md_o[2]), .vec_mask(vm_o[2]), .vec_pend(vp_o[2]));

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int k, input logic [2:0] a, input logic [3:0] b,
                    input logic [31:0] d);
    @(negedge clk);
    we[k] = 1'b1; ad[k] = a; be[k] = b; wd[k] = d;
    @(negedge clk);
    we[k] = 1'b0; be[k] = 4'h0; wd[k] = 32'd0;
  endtask

  task automatic rdchk(input int k, input logic [2:0] a, input logic [31:0] exp,
                       input string req, input string what);
    @(negedge clk);
    ad[k] = a;
    #1;
    chk(req, what, {32'd0, rd_o[k]}, {32'd0, exp});
  endtask

  task automatic gen(input int k, input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    ps[k] = s; pc[k] = c;
    @(negedge clk);
    ps[k] = 32'd0; pc[k] = 32'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_layout();
    rdchk(0, 3'd0, 32'h0186_0005, "R1", "A ctrl after reset");
    for (int a = 1; a < 6; a++) rdchk(0, 3'(a), 32'd0, "R1", "A word after reset");
    rdchk(1, 3'd0, 32'h010A_0005, "R2", "B ctrl layout");
    for (int a = 1; a < 5; a++) rdchk(1, 3'(a), 32'd0, "R1", "B word after reset");
    rdchk(2, 3'd0, 32'h0000_0005, "R2", "C ctrl layout");
    chk("R12", "A enable out", {63'd0, en_o[0]}, 64'd0);
    chk("R12", "A addr out", ma_o[0], 64'd0);
  endtask

  task automatic t_ctrl();
    wr(0, 3'd0, 4'hF, 32'h0021_FFFF);
    rdchk(0, 3'd0, 32'h01A7_0005, "R3", "A ro fields kept, rw fields set");
    chk("R12", "A enable out", {63'd0, en_o[0]}, 64'd1);
    chk("R12", "A granted out", {61'd0, vl_o[0]}, 64'd2);
    wr(0, 3'd0, 4'h4, 32'h0071_0000);
    rdchk(0, 3'd0, 32'h01B7_0005, "R8", "A clamp 7->3");
    wr(1, 3'd0, 4'h4, 32'h0061_0000);
    rdchk(1, 3'd0, 32'h015B_0005, "R8", "B clamp 6->5");
    wr(2, 3'd0, 4'h4, 32'h0031_0000);
    rdchk(2, 3'd0, 32'h0001_0005, "R8", "C clamp 3->0");
    wr(0, 3'd0, 4'hB, 32'h0000_0000);
    rdchk(0, 3'd0, 32'h01B7_0005, "R6", "A byte2 disabled keeps ctrl");
  endtask

  task automatic t_addr_data();
    wr(0, 3'd1, 4'hF, 32'hDEAD_BEEF);
    rdchk(0, 3'd1, 32'hDEAD_BEEC, "R4", "A low addr bits[1:0] zero");
    wr(0, 3'd2, 4'hF, 32'h1234_5678);
    rdchk(0, 3'd2, 32'h1234_5678, "R4", "A high addr");
    wr(0, 3'd1, 4'h1, 32'hFFFF_FF13);
    rdchk(0, 3'd1, 32'hDEAD_BE10, "R6", "A low addr byte0 only");
    chk("R12", "A msg_addr", ma_o[0], 64'h1234_5678_DEAD_BE10);
    wr(0, 3'd3, 4'hF, 32'hCAFE_F00D);
    rdchk(0, 3'd3, 32'h0000_F00D, "R5", "A data 16 bits");
    chk("R12", "A msg_data", {48'd0, md_o[0]}, 64'h0000_0000_0000_F00D);
    wr(1, 3'd2, 4'hF, 32'hABCD_1234);
    rdchk(1, 3'd2, 32'h0000_1234, "R2", "B data at dword 2");
    wr(1, 3'd1, 4'hF, 32'hFFFF_FFFF);
    chk("R4", "B no high addr", ma_o[1], 64'h0000_0000_FFFF_FFFC);
  endtask

  task automatic t_mask();
    wr(0, 3'd4, 4'hF, 32'hFFFF_FFFF);
    rdchk(0, 3'd4, 32'h0000_00FF, "R7", "A mask limited to 8");
    chk("R12", "A vec_mask", {32'd0, vm_o[0]}, 64'hFF);
    wr(1, 3'd3, 4'hF, 32'hFFFF_FFFF);
    rdchk(1, 3'd3, 32'hFFFF_FFFF, "R7", "B mask full 32");
    wr(0, 3'd5, 4'hF, 32'h0000_00FF);
    rdchk(0, 3'd5, 32'h0000_0000, "R10", "A pending ignores cfg write");
  endtask

  task automatic t_pending();
    wr(0, 3'd0, 4'h4, 32'h0001_0000);          // granted log2 = 0
    gen(0, 32'h0000_0108, 32'd0);              // bit 8 beyond 8 vectors
    rdchk(0, 3'd5, 32'h0000_0008, "R10", "A set limited to requested");
    wr(0, 3'd6, 4'hF, 32'hFFFF_FFFF);
    rdchk(0, 3'd5, 32'h0000_0008, "R11", "A outside write no trim");
    rdchk(0, 3'd6, 32'h0000_0000, "R11", "A outside read zero");
    rdchk(0, 3'd7, 32'h0000_0000, "R11", "A outside read zero");
    wr(2, 3'd3, 4'hF, 32'hFFFF_FFFF);
    rdchk(2, 3'd3, 32'h0000_0000, "R11", "C dword 3 outside");
    rdchk(2, 3'd0, 32'h0001_0005, "R11", "C ctrl untouched");
    wr(0, 3'd3, 4'h1, 32'h0000_000D);
    rdchk(0, 3'd5, 32'h0000_0000, "R9", "A trim to 1 vector");
    wr(0, 3'd0, 4'h4, 32'h0031_0000);
    gen(0, 32'h0000_0021, 32'd0);
    chk("R12", "A vec_pend", {32'd0, vp_o[0]}, 64'h21);
    gen(0, 32'h0000_0001, 32'h0000_0001);
    rdchk(0, 3'd5, 32'h0000_0020, "R10", "A clear wins over set");
    wr(0, 3'd0, 4'h4, 32'h0021_0000);
    rdchk(0, 3'd5, 32'h0000_0000, "R9", "A trim to 4 vectors");
    gen(1, 32'h8000_0000, 32'd0);
    rdchk(1, 3'd4, 32'h8000_0000, "R10", "B set top vector");
    gen(2, 32'h0000_0001, 32'd0);
    chk("R13", "C no pending", {32'd0, vp_o[2]}, 64'd0);
    chk("R13", "C no mask", {32'd0, vm_o[2]}, 64'd0);
  endtask

  task automatic t_reset_again();
    do_reset();
    rdchk(0, 3'd0, 32'h0186_0005, "R1", "A ctrl after second reset");
    for (int a = 1; a < 6; a++) rdchk(0, 3'(a), 32'd0, "R1", "A word after second reset");
    rdchk(1, 3'd4, 32'd0, "R1", "B pending after second reset");
  endtask

  initial begin
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      we[k] = 1'b0; ad[k] = 3'd0; be[k] = 4'h0; wd[k] = 32'd0;
      ps[k] = 32'd0; pc[k] = 32'd0;
    end
    do_reset();
    t_reset_layout();
    t_ctrl();
    t_addr_data();
    t_mask();
    t_pending();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule